// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Doorbell

This block is the control window a host processor uses to run a small embedded coprocessor. The host sees a 32-bit register bus with a run/reset control register, a memory split setting, a doorbell toward the coprocessor, an interrupt status register, a program counter readback and a watchdog control register. A second port carries coprocessor-side events: a pulse that accepts a pending doorbell, a pulse that raises a message interrupt, and a pulse that kicks the watchdog.

Each direction carries one item at a time. The host writes 1 to the doorbell and must wait for it to read 0 before it sends again. The coprocessor raises a message interrupt only when the status register is empty, and the host frees the status register by writing 0 to it. The same status register reports watchdog expiry: bit 8 marks a message and bit 0 marks a timeout. The host sees a timeout as a nonzero value with bit 8 clear, and it responds by writing 0 to the run register. The watchdog is a down-counter. It runs only while its enable bit is set and the coprocessor is out of reset, and it reports through the status register.

Top module: `cop_mailbox`

## Requirements
- R1: After reset, cop_reset_n and host_irq are 0, and every register reads 0.
- R2: Writing offset 0x00 stores wdata bit 0. It reads back in bit 0, and cop_reset_n follows it from the next cycle (1 = running, 0 = held in reset).
- R3: A write to offset 0x24 with wdata bit 0 = 1 sets the doorbell, which then reads 1. A cop_accept pulse clears it to 0 in the next cycle. A write of 1 while the doorbell is already set is ignored, and so is a write of 0.
- R4: A cop_ipc pulse while the status register (offset 0x1C) is 0 sets status bit 8. host_irq is 1 whenever status is nonzero.
- R5: A cop_ipc pulse while status is nonzero leaves status unchanged.
- R6: A host write of 0 to offset 0x1C clears status, and host_irq is 0 from the next cycle. A nonzero write to 0x1C has no effect.
- R7: Offset 0x84 bit 31 enables the watchdog and reads back, with all other bits 0. While it is enabled and the run bit is 1, the counter counts down from WDT_RELOAD. In the cycle it is found at 0 it sets status bit 0 and reloads. While the watchdog is disabled or the coprocessor is in reset, the counter holds at WDT_RELOAD.
- R8: A cop_kick pulse reloads the watchdog counter to WDT_RELOAD, so a kick every few cycles keeps status bit 0 from ever setting.
- R9: A watchdog expiry sets status bit 0 even when status is already nonzero, so it is never lost.
- R10: Offset 0x08 stores wdata bits 1:0 as the memory split field and reads them back in bits 1:0. Value 2 selects 96 KiB program memory with 32 KiB data memory.
- R11: Offset 0x60 reads the cop_pc input.
- R12: A read of any other offset returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cop_accept | input | 1 | Coprocessor has taken the doorbell command |
| cop_ipc | input | 1 | Coprocessor raises a message interrupt |
| cop_kick | input | 1 | Coprocessor reloads the watchdog |
| cop_pc | input | 32 | Coprocessor program counter, for readback |
| host_irq | output | 1 | Level interrupt to the host |
| cop_reset_n | output | 1 | Reset to the coprocessor, 1 = run |

## Verification
A doorbell bit that sticks at 1 or drops at 0 shows on the first read of 0x24 after the next accept or write. A status register that wrongly lets a second message through, or that loses a watchdog cause, changes host_irq or the 0x1C readback in the very next cycle. A watchdog counter off by one moves the rising edge of host_irq by one cycle. The bench reads back the register under the current address and compares it against its model on every clock, so any of these faults shows at the latest one cycle after the wrong state forms.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int OFF_RUN = 'h00;
  localparam int OFF_CFG = 'h08;
  localparam int OFF_ST  = 'h1C;
  localparam int OFF_DB  = 'h24;
  localparam int OFF_PC  = 'h60;
  localparam int OFF_WDT = 'h84;
  localparam int IPC_BIT = 8;
  localparam int WDT_BIT = 0;
  localparam int WEN_BIT = 31;
  localparam int CFG_W   = 2;

  // next status: clear by zero write, message only into an empty register, expiry always
  function automatic logic [31:0] status_next(input logic [31:0] cur, input logic clr,
                                              input logic raise, input logic expire);
    logic [31:0] nxt;
    nxt = clr ? 32'd0 : cur;
    if (raise && cur == 32'd0) nxt[IPC_BIT] = 1'b1;
    if (expire) nxt[WDT_BIT] = 1'b1;
    return nxt;
  endfunction
endpackage

// File: rtl/cmb_doorbell.sv
module cmb_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic host_set,
  input  logic accept,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (pending) pending <= !accept;
    else              pending <= host_set;
  end
endmodule

// File: rtl/cmb_status.sv
module cmb_status
  import cmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_clr,
  input  logic        ipc_raise,
  input  logic        wdt_expire,
  output logic [31:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= 32'd0;
    else        status <= status_next(status, host_clr, ipc_raise, wdt_expire);
  end
endmodule

// File: rtl/cmb_watchdog.sv
module cmb_watchdog #(
  parameter int RELOAD = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic running,
  input  logic kick,
  output logic expire
);
  localparam int CNT_W = $clog2(RELOAD + 1);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt;
  logic             active;

  assign active = enable && running;
  assign expire = active && !kick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= RELOAD_V;
    else if (!active || kick || expire) cnt <= RELOAD_V;
    else                               cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/cop_mailbox.sv
module cop_mailbox
  import cmb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WDT_RELOAD = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cop_accept,
  input  logic              cop_ipc,
  input  logic              cop_kick,
  input  logic [31:0]       cop_pc,
  output logic              host_irq,
  output logic              cop_reset_n
);
  logic             wr;
  logic             wr_run, wr_cfg, wr_st, wr_db, wr_wdt;
  logic             run_q, wdt_en_q, db_q, wdt_expire;
  logic [CFG_W-1:0] cfg_q;
  logic [31:0]      st_q;

  assign wr     = bus_sel && bus_we;
  assign wr_run = wr && (bus_addr == ADDR_W'(OFF_RUN));
  assign wr_cfg = wr && (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_st  = wr && (bus_addr == ADDR_W'(OFF_ST));
  assign wr_db  = wr && (bus_addr == ADDR_W'(OFF_DB));
  assign wr_wdt = wr && (bus_addr == ADDR_W'(OFF_WDT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cfg_q    <= '0;
      wdt_en_q <= 1'b0;
    end else begin
      if (wr_run) run_q    <= bus_wdata[0];
      if (wr_cfg) cfg_q    <= bus_wdata[CFG_W-1:0];
      if (wr_wdt) wdt_en_q <= bus_wdata[WEN_BIT];
    end
  end

  cmb_doorbell u_db (
    .clk(clk), .rst_n(rst_n),
    .host_set(wr_db && bus_wdata[0]),
    .accept(cop_accept),
    .pending(db_q)
  );

  cmb_status u_st (
    .clk(clk), .rst_n(rst_n),
    .host_clr(wr_st && (bus_wdata == 32'd0)),
    .ipc_raise(cop_ipc),
    .wdt_expire(wdt_expire),
    .status(st_q)
  );

  cmb_watchdog #(.RELOAD(WDT_RELOAD)) u_wdt (
    .clk(clk), .rst_n(rst_n),
    .enable(wdt_en_q),
    .running(run_q),
    .kick(cop_kick),
    .expire(wdt_expire)
  );

  assign host_irq    = (st_q != 32'd0);
  assign cop_reset_n = run_q;

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == ADDR_W'(OFF_RUN))      bus_rdata[0] = run_q;
    else if (bus_addr == ADDR_W'(OFF_CFG)) bus_rdata[CFG_W-1:0] = cfg_q;
    else if (bus_addr == ADDR_W'(OFF_ST))  bus_rdata = st_q;
    else if (bus_addr == ADDR_W'(OFF_DB))  bus_rdata[0] = db_q;
    else if (bus_addr == ADDR_W'(OFF_PC))  bus_rdata = cop_pc;
    else if (bus_addr == ADDR_W'(OFF_WDT)) bus_rdata[WEN_BIT] = wdt_en_q;
  end
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_run,
  input logic        wr_db,
  input logic        wr_st,
  input logic [31:0] bus_wdata,
  input logic        cop_accept,
  input logic        cop_ipc,
  input logic        db_q,
  input logic [31:0] st_q,
  input logic        wdt_expire,
  input logic        wdt_en_q,
  input logic        run_q,
  input logic        host_irq,
  input logic        cop_reset_n
);
  // R3
  db_accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_q && cop_accept |=> !db_q);
  // R3
  db_holds_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_q && !cop_accept |=> db_q);
  // R3
  db_set_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !db_q && !(wr_db && bus_wdata[0]) |=> !db_q);
  // R5
  ipc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 32'd0) && !wr_st && !wdt_expire |=> $stable(st_q));
  // R4
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(cop_ipc || wdt_expire));
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st && (bus_wdata == 32'd0) && !cop_ipc && !wdt_expire |=> !host_irq);
  // R7
  wdt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |-> wdt_en_q && run_q);
  // R2
  run_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_run |=> $stable(cop_reset_n));
endmodule

bind cop_mailbox cmb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_run(wr_run), .wr_db(wr_db), .wr_st(wr_st),
  .bus_wdata(bus_wdata), .cop_accept(cop_accept), .cop_ipc(cop_ipc),
  .db_q(db_q), .st_q(st_q), .wdt_expire(wdt_expire), .wdt_en_q(wdt_en_q),
  .run_q(run_q), .host_irq(host_irq), .cop_reset_n(cop_reset_n)
);

// File: tb/test_cop_mailbox.sv
`timescale 1ns/1ps
module test_cop_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int RELOAD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        cop_accept = 1'b0, cop_ipc = 1'b0, cop_kick = 1'b0;
  logic [31:0] cop_pc = 32'h0000_1234;
  logic        host_irq, cop_reset_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  cop_mailbox #(.ADDR_W(8), .WDT_RELOAD(RELOAD)) i_cop_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cop_accept(cop_accept), .cop_ipc(cop_ipc), .cop_kick(cop_kick),
    .cop_pc(cop_pc), .host_irq(host_irq), .cop_reset_n(cop_reset_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model
  bit     m_run, m_wen, m_db;
  int     m_cfg;
  int     m_cnt = RELOAD;
  bit [31:0] m_st;

  always @(posedge clk) begin
    bit w, act, exp_now;
    bit [31:0] st_n;
    w = bus_sel && bus_we;
    if (!rst_n) begin
      m_run = 0; m_wen = 0; m_db = 0; m_cfg = 0; m_cnt = RELOAD; m_st = 0;
    end else begin
      act = m_wen && m_run;
      exp_now = act && !cop_kick && (m_cnt == 0);
      st_n = (w && bus_addr == 8'h1C && bus_wdata == 0) ? 32'd0 : m_st;
      if (cop_ipc && m_st == 0) st_n = st_n | 32'h100;
      if (exp_now) st_n = st_n | 32'h1;
      if (m_db) m_db = !cop_accept;
      else      m_db = w && bus_addr == 8'h24 && bus_wdata[0];
      if (!act || cop_kick || exp_now) m_cnt = RELOAD; else m_cnt = m_cnt - 1;
      m_st = st_n;
      if (w && bus_addr == 8'h00) m_run = bus_wdata[0];
      if (w && bus_addr == 8'h08) m_cfg = bus_wdata[1:0];
      if (w && bus_addr == 8'h84) m_wen = bus_wdata[31];
    end
  end

  function automatic bit [31:0] m_read(input bit [7:0] a);
    case (a)
      8'h00: return {31'd0, m_run};
      8'h08: return 32'(m_cfg);
      8'h1C: return m_st;
      8'h24: return {31'd0, m_db};
      8'h60: return cop_pc;
      8'h84: return {m_wen, 31'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input bit [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h08: return "R10";
      8'h1C: return "R5";
      8'h24: return "R3";
      8'h60: return "R11";
      8'h84: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison, at the falling edge before new stimulus
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R4 host_irq", {31'd0, host_irq}, {31'd0, m_st != 0});
      chk("R2 cop_reset_n", {31'd0, cop_reset_n}, {31'd0, m_run});
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic idle;
    bus_sel = 0; bus_we = 0; cop_accept = 0; cop_ipc = 0; cop_kick = 0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    step(); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step(); idle();
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string req);
    step(); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    step(); idle();
  endtask

  task automatic pulse_accept; step(); cop_accept = 1; step(); idle(); endtask
  task automatic pulse_ipc;    step(); cop_ipc = 1;    step(); idle(); endtask
  task automatic pulse_kick;   step(); cop_kick = 1;   step(); idle(); endtask

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 reset_n", {31'd0, cop_reset_n}, 32'd0);
    chk("R1 irq", {31'd0, host_irq}, 32'd0);
    rst_n = 1;
    rd(8'h00, 32'd0, "R1 run");
    rd(8'h1C, 32'd0, "R1 status");
    rd(8'h24, 32'd0, "R1 doorbell");
    rd(8'h84, 32'd0, "R1 wdt");

    // R2 run control
    wr(8'h00, 32'd1);
    chk("R2 released", {31'd0, cop_reset_n}, 32'd1);
    rd(8'h00, 32'd1, "R2 run readback");
    wr(8'h00, 32'd0);
    chk("R2 held", {31'd0, cop_reset_n}, 32'd0);

    // R10 memory split, R11 pc
    wr(8'h08, 32'hFFFF_FFF2);
    rd(8'h08, 32'd2, "R10 split");
    cop_pc = 32'hDEAD_0040;
    rd(8'h60, 32'hDEAD_0040, "R11 pc");

    // R3 doorbell
    wr(8'h24, 32'd0);
    rd(8'h24, 32'd0, "R3 zero write ignored");
    wr(8'h24, 32'd1);
    rd(8'h24, 32'd1, "R3 set");
    wr(8'h24, 32'd1);
    pulse_accept();
    rd(8'h24, 32'd0, "R3 second write ignored");
    pulse_accept();
    rd(8'h24, 32'd0, "R3 accept when empty");

    // R4 R5 R6 status handshake
    pulse_ipc();
    chk("R4 irq", {31'd0, host_irq}, 32'd1);
    rd(8'h1C, 32'h100, "R4 status");
    pulse_ipc();
    rd(8'h1C, 32'h100, "R5 blocked");
    wr(8'h1C, 32'h100);
    rd(8'h1C, 32'h100, "R6 nonzero write ignored");
    wr(8'h1C, 32'd0);
    chk("R6 irq low", {31'd0, host_irq}, 32'd0);
    pulse_ipc();
    rd(8'h1C, 32'h100, "R4 again");
    wr(8'h1C, 32'd0);

    // R12 undefined offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h04, 32'd0, "R12 read");
    rd(8'h00, 32'd0, "R12 run untouched");
    rd(8'h24, 32'd0, "R12 doorbell untouched");

    // R7 watchdog gated by run
    wr(8'h84, 32'h8000_0000);
    rd(8'h84, 32'h8000_0000, "R7 enable readback");
    repeat (RELOAD + 5) step();
    chk("R7 no count in reset", {31'd0, host_irq}, 32'd0);
    wr(8'h00, 32'd1);
    repeat (RELOAD - 4) step();
    chk("R7 not yet", {31'd0, host_irq}, 32'd0);
    repeat (8) step();
    chk("R7 expired", {31'd0, host_irq}, 32'd1);
    rd(8'h1C, 32'h1, "R7 status bit0");
    wr(8'h84, 32'd0);
    wr(8'h1C, 32'd0);

    // R8 kick
    wr(8'h84, 32'h8000_0000);
    for (int i = 0; i < 10; i++) begin
      repeat (RELOAD - 6) step();
      pulse_kick();
    end
    chk("R8 kicked", {31'd0, host_irq}, 32'd0);

    // R9 expiry while message pending
    pulse_ipc();
    repeat (RELOAD + 6) step();
    rd(8'h1C, 32'h101, "R9 both causes");
    wr(8'h84, 32'd0);
    wr(8'h1C, 32'd0);
    chk("R6 cleared", {31'd0, host_irq}, 32'd0);

    repeat (3) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule